// File: doc/BRIEF.md
# Flash Write-Protect Command Gate

This block sits behind the serial front end of a small flash memory and decides, for each fully received command, whether it may run. The front end reports, at the moment chip select rises, the opcode, the number of bits clocked during the select (opcode included), the 24-bit address and the first data byte. The gate owns the status register, with the busy flag, the write-enable latch, three block-protect bits, a top/bottom select and a register-protect bit. It issues a one-cycle start pulse, carrying an operation kind and address, for program, erase and status-write operations.

A cycle-count busy timer, with one length parameter per operation class, models the self-timed operation. While it runs, the gate refuses everything except a status read. The gate also tracks a deep power-down state and a one-time-programmable (OTP) mode. For page programming it turns a byte index into an array address that wraps inside the 256-byte page. Array storage and bit shifting belong to other blocks.

Top module: `wp_cmd_gate`

## Requirements
- R1: Opcode 06h sets the write-enable latch (status bit 1) and opcode 04h clears it. The latch also clears on the cycle in which any timed operation completes.
- R2: Program (02h), erase (20h, 52h, D8h, C7h, 60h) and status write (01h) are refused unless the latch is 1 when the command arrives.
- R3: A state-changing command is refused unless its bit count is a multiple of 8. Program needs at least 40 bits and erases with an address need at least 32. A status write needs exactly 16 or 24 bits, which is one or two data bytes.
- R4: While busy (status bit 0), every command other than status read (05h) is ignored. A status read is acknowledged on `rdsr_ack` in the cycle after it arrives.
- R5: When the register-protect bit (status bit 7) is 1 and `wp_n` is low, a status write is refused.
- R6: Protection depends on BP1 (status bit 3), BP0 (status bit 2) and TB (status bit 5). If BP1 is 1, all 64 KB is protected. If BP1:BP0 is 01, address bit 15 = 1 is protected when TB is 0 and address bit 15 = 0 when TB is 1. If BP1:BP0 is 00, nothing is protected. BP2 (status bit 4) is stored but has no effect on protection.
- R7: Program, sector erase and 32 KB erase that target a protected half are refused. A 64 KB erase and a chip erase are refused whenever any region is protected.
- R8: After B9h the block is powered down: every command except ABh is ignored, status read included. ABh is acknowledged on `wake_ack` and ends power-down.
- R9: `pp_byte_addr` equals the upper 16 bits of the last program address, joined to the sum of its low byte and `pp_byte_idx` taken modulo 256.
- R10: Busy rises in the same cycle as `op_start` and stays high for exactly the parameterised cycle count of that operation class.
- R11: After reset the status byte reads 00h. Its layout is register-protect at bit 7, bit 6 zero, TB at bit 5, BP2..BP0 at bits 4..2, the latch at bit 1 and busy at bit 0. A status write loads bits 7, 5, 4, 3 and 2 from `cmd_data` when it completes.
- R12: Opcode 3Ah enters OTP mode and 04h leaves it. In OTP mode a status write ignores its data and sets only the register-protect bit.
- R13: An accepted operation pulses `op_start` for one cycle. In that cycle `op_kind` reads 0 for program, 1 for sector erase, 2 for 32 KB erase, 3 for 64 KB erase, 4 for chip erase and 5 for status write, and `op_addr` holds the command address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle event: chip select rose with a complete command |
| cmd_op | input | 8 | Opcode byte |
| cmd_bits | input | 16 | Bits clocked during the select, opcode included |
| cmd_addr | input | 24 | Command address |
| cmd_data | input | 8 | First data byte (status-write value) |
| wp_n | input | 1 | Write-protect pin, active low |
| pp_byte_idx | input | 8 | Byte index within the current page program |
| status_q | output | 8 | Status register contents |
| op_start | output | 1 | One-cycle launch pulse |
| op_kind | output | 3 | Kind of the launched operation |
| op_addr | output | 24 | Address of the launched operation |
| pp_byte_addr | output | 24 | Page-wrapped array address for the byte index |
| rdsr_ack | output | 1 | Status read accepted |
| wake_ack | output | 1 | Release command accepted |
| pd_state | output | 1 | Power-down active |
| otp_state | output | 1 | OTP mode active |

## Verification
The write-enable latch can be set by 06h and cleared by the end of a timed operation in the same cycle. The gate resolves this because 06h is refused while busy. The bench sends 06h in the middle of an erase and then reads the status byte after busy falls: the latch must be 0, which shows that the completion clear won and the busy-time command left no trace. The bench also sends a status read during the same erase and expects it to be acknowledged while the erase keeps running.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam logic [7:0] OPC_WRDI  = 8'h04;
  localparam logic [7:0] OPC_RDSR  = 8'h05;
  localparam logic [7:0] OPC_WRSR  = 8'h01;
  localparam logic [7:0] OPC_PROG  = 8'h02;
  localparam logic [7:0] OPC_SECT  = 8'h20;
  localparam logic [7:0] OPC_BLK32 = 8'h52;
  localparam logic [7:0] OPC_BLK64 = 8'hD8;
  localparam logic [7:0] OPC_CHIPA = 8'hC7;
  localparam logic [7:0] OPC_CHIPB = 8'h60;
  localparam logic [7:0] OPC_SLEEP = 8'hB9;
  localparam logic [7:0] OPC_WAKE  = 8'hAB;
  localparam logic [7:0] OPC_OTP   = 8'h3A;

  localparam logic [2:0] K_PROG  = 3'd0;
  localparam logic [2:0] K_SECT  = 3'd1;
  localparam logic [2:0] K_BLK32 = 3'd2;
  localparam logic [2:0] K_BLK64 = 3'd3;
  localparam logic [2:0] K_CHIP  = 3'd4;
  localparam logic [2:0] K_WRSR  = 3'd5;

  // Protection of one 32 KB half, chosen by address bit 15.
  function automatic logic half_locked(input logic [1:0] bp_lo, input logic tb,
                                       input logic upper);
    if (bp_lo[1])            return 1'b1;
    else if (bp_lo == 2'b01) return tb ? !upper : upper;
    else                     return 1'b0;
  endfunction

  function automatic logic any_locked(input logic [1:0] bp_lo);
    return bp_lo != 2'b00;
  endfunction

  // Address of a byte inside a page program; wraps within the page.
  function automatic logic [23:0] page_wrap(input logic [23:0] base,
                                            input logic [7:0] idx);
    logic [7:0] low;
    low = base[7:0] + idx;
    return {base[23:8], low};
  endfunction
endpackage

// File: rtl/wpg_decode.sv
module wpg_decode
  import wpg_pkg::*;
#(
  parameter int BITS_W = 16
) (
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic [BITS_W-1:0] cmd_bits,
  input  logic [23:0]       cmd_addr,
  input  logic              wp_n,
  input  logic              wip,
  input  logic              wel,
  input  logic              srp,
  input  logic              tb,
  input  logic [2:0]        bp,
  input  logic              pd,
  output logic              go_wren,
  output logic              go_wrdi,
  output logic              go_rdsr,
  output logic              go_sleep,
  output logic              go_wake,
  output logic              go_otp,
  output logic              go_launch,
  output logic [2:0]        launch_kind
);
  localparam logic [BITS_W-1:0] LEN_BYTE = BITS_W'(8);
  localparam logic [BITS_W-1:0] LEN_ADDR = BITS_W'(32);
  localparam logic [BITS_W-1:0] LEN_PROG = BITS_W'(40);
  localparam logic [BITS_W-1:0] LEN_SR1  = BITS_W'(16);
  localparam logic [BITS_W-1:0] LEN_SR2  = BITS_W'(24);

  logic byte_ok, idle_gate, simple_ok;
  logic is_write, len_ok, target_locked;

  assign byte_ok   = (cmd_bits[2:0] == 3'b000) && (cmd_bits >= LEN_BYTE);
  assign idle_gate = cmd_valid && !wip && !pd;
  assign simple_ok = idle_gate && byte_ok;

  assign go_rdsr  = cmd_valid && !pd && (cmd_op == OPC_RDSR);
  assign go_wake  = cmd_valid && !wip && (cmd_op == OPC_WAKE);
  assign go_wren  = simple_ok && (cmd_op == OPC_WREN);
  assign go_wrdi  = simple_ok && (cmd_op == OPC_WRDI);
  assign go_sleep = simple_ok && (cmd_op == OPC_SLEEP);
  assign go_otp   = simple_ok && (cmd_op == OPC_OTP);

  always_comb begin
    is_write      = 1'b1;
    len_ok        = 1'b0;
    target_locked = 1'b0;
    launch_kind   = K_PROG;
    case (cmd_op)
      OPC_PROG: begin
        launch_kind   = K_PROG;
        len_ok        = cmd_bits >= LEN_PROG;
        target_locked = half_locked(bp[1:0], tb, cmd_addr[15]);
      end
      OPC_SECT: begin
        launch_kind   = K_SECT;
        len_ok        = cmd_bits >= LEN_ADDR;
        target_locked = half_locked(bp[1:0], tb, cmd_addr[15]);
      end
      OPC_BLK32: begin
        launch_kind   = K_BLK32;
        len_ok        = cmd_bits >= LEN_ADDR;
        target_locked = half_locked(bp[1:0], tb, cmd_addr[15]);
      end
      OPC_BLK64: begin
        launch_kind   = K_BLK64;
        len_ok        = cmd_bits >= LEN_ADDR;
        target_locked = any_locked(bp[1:0]);
      end
      OPC_CHIPA, OPC_CHIPB: begin
        launch_kind   = K_CHIP;
        len_ok        = 1'b1;
        target_locked = any_locked(bp[1:0]);
      end
      OPC_WRSR: begin
        launch_kind   = K_WRSR;
        len_ok        = (cmd_bits == LEN_SR1) || (cmd_bits == LEN_SR2);
        target_locked = srp && !wp_n;
      end
      default: is_write = 1'b0;
    endcase
  end

  assign go_launch = simple_ok && is_write && len_ok && wel && !target_locked;
endmodule

// File: rtl/wpg_busy.sv
module wpg_busy
  import wpg_pkg::*;
#(
  parameter int T_PROG  = 20,
  parameter int T_SECT  = 40,
  parameter int T_BLK32 = 60,
  parameter int T_BLK64 = 80,
  parameter int T_CHIP  = 100,
  parameter int T_WRSR  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch,
  input  logic [2:0] kind,
  output logic       wip,
  output logic       done
);
  localparam int T_MAX = (T_PROG > T_SECT ? T_PROG : T_SECT) >
                         (T_BLK32 > T_BLK64 ? T_BLK32 : T_BLK64) ?
                         (T_PROG > T_SECT ? T_PROG : T_SECT) :
                         (T_BLK32 > T_BLK64 ? T_BLK32 : T_BLK64);
  localparam int T_TOP = (T_MAX > T_CHIP ? T_MAX : T_CHIP) > T_WRSR ?
                         (T_MAX > T_CHIP ? T_MAX : T_CHIP) : T_WRSR;
  localparam int CW = $clog2(T_TOP + 1);

  logic [CW-1:0] remain;

  function automatic logic [CW-1:0] span_of(input logic [2:0] k);
    case (k)
      K_PROG:  return CW'(T_PROG - 1);
      K_SECT:  return CW'(T_SECT - 1);
      K_BLK32: return CW'(T_BLK32 - 1);
      K_BLK64: return CW'(T_BLK64 - 1);
      K_CHIP:  return CW'(T_CHIP - 1);
      default: return CW'(T_WRSR - 1);
    endcase
  endfunction

  assign done = wip && (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wip    <= 1'b0;
      remain <= '0;
    end else if (launch) begin
      wip    <= 1'b1;
      remain <= span_of(kind);
    end else if (done) begin
      wip    <= 1'b0;
    end else if (wip) begin
      remain <= remain - 1'b1;
    end
  end

  a_r10_launch_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> wip);
  a_r10_no_launch_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> !launch);
endmodule

// File: rtl/wpg_status.sv
module wpg_status
  import wpg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_wren,
  input  logic       go_wrdi,
  input  logic       go_sleep,
  input  logic       go_wake,
  input  logic       go_otp,
  input  logic       go_launch,
  input  logic [2:0] launch_kind,
  input  logic [7:0] wr_byte,
  input  logic       done,
  output logic       wel,
  output logic       srp,
  output logic       tb,
  output logic [2:0] bp,
  output logic       pd,
  output logic       otp
);
  logic       pend_wrsr;
  logic       pend_otp;
  logic [7:0] pend_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel       <= 1'b0;
      srp       <= 1'b0;
      tb        <= 1'b0;
      bp        <= 3'b000;
      pd        <= 1'b0;
      otp       <= 1'b0;
      pend_wrsr <= 1'b0;
      pend_otp  <= 1'b0;
      pend_byte <= 8'h00;
    end else begin
      if (go_wren) wel <= 1'b1;
      if (go_wrdi) begin
        wel <= 1'b0;
        otp <= 1'b0;
      end
      if (go_otp)   otp <= 1'b1;
      if (go_sleep) pd  <= 1'b1;
      if (go_wake)  pd  <= 1'b0;
      if (go_launch) begin
        pend_wrsr <= (launch_kind == K_WRSR);
        pend_otp  <= otp;
        pend_byte <= wr_byte;
      end
      if (done) begin
        wel       <= 1'b0;
        pend_wrsr <= 1'b0;
        if (pend_wrsr) begin
          if (pend_otp) begin
            srp <= 1'b1;
          end else begin
            srp <= pend_byte[7];
            tb  <= pend_byte[5];
            bp  <= pend_byte[4:2];
          end
        end
      end
    end
  end

  a_r1_done_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !wel);
  a_r12_otp_write_sets_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pend_wrsr && pend_otp) |=> srp);
endmodule

// File: rtl/wp_cmd_gate.sv
module wp_cmd_gate
  import wpg_pkg::*;
#(
  parameter int BITS_W  = 16,
  parameter int T_PROG  = 20,
  parameter int T_SECT  = 40,
  parameter int T_BLK32 = 60,
  parameter int T_BLK64 = 80,
  parameter int T_CHIP  = 100,
  parameter int T_WRSR  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic [BITS_W-1:0] cmd_bits,
  input  logic [23:0]       cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic              wp_n,
  input  logic [7:0]        pp_byte_idx,
  output logic [7:0]        status_q,
  output logic              op_start,
  output logic [2:0]        op_kind,
  output logic [23:0]       op_addr,
  output logic [23:0]       pp_byte_addr,
  output logic              rdsr_ack,
  output logic              wake_ack,
  output logic              pd_state,
  output logic              otp_state
);
  logic       wip, done, wel, srp, tb, pd, otp;
  logic [2:0] bp;
  logic       go_wren, go_wrdi, go_rdsr, go_sleep, go_wake, go_otp, go_launch;
  logic [2:0] launch_kind;
  logic [23:0] prog_base;

  wpg_decode #(.BITS_W(BITS_W)) u_decode (
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bits(cmd_bits),
    .cmd_addr(cmd_addr), .wp_n(wp_n), .wip(wip), .wel(wel), .srp(srp),
    .tb(tb), .bp(bp), .pd(pd),
    .go_wren(go_wren), .go_wrdi(go_wrdi), .go_rdsr(go_rdsr),
    .go_sleep(go_sleep), .go_wake(go_wake), .go_otp(go_otp),
    .go_launch(go_launch), .launch_kind(launch_kind)
  );

  wpg_busy #(
    .T_PROG(T_PROG), .T_SECT(T_SECT), .T_BLK32(T_BLK32),
    .T_BLK64(T_BLK64), .T_CHIP(T_CHIP), .T_WRSR(T_WRSR)
  ) u_busy (
    .clk(clk), .rst_n(rst_n), .launch(go_launch), .kind(launch_kind),
    .wip(wip), .done(done)
  );

  wpg_status u_status (
    .clk(clk), .rst_n(rst_n), .go_wren(go_wren), .go_wrdi(go_wrdi),
    .go_sleep(go_sleep), .go_wake(go_wake), .go_otp(go_otp),
    .go_launch(go_launch), .launch_kind(launch_kind), .wr_byte(cmd_data),
    .done(done), .wel(wel), .srp(srp), .tb(tb), .bp(bp), .pd(pd), .otp(otp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_start  <= 1'b0;
      op_kind   <= K_PROG;
      op_addr   <= 24'h0;
      prog_base <= 24'h0;
      rdsr_ack  <= 1'b0;
      wake_ack  <= 1'b0;
    end else begin
      op_start <= go_launch;
      rdsr_ack <= go_rdsr;
      wake_ack <= go_wake;
      if (go_launch) begin
        op_kind <= launch_kind;
        op_addr <= cmd_addr;
        if (launch_kind == K_PROG) prog_base <= cmd_addr;
      end
    end
  end

  assign status_q     = {srp, 1'b0, tb, bp, wel, wip};
  assign pp_byte_addr = page_wrap(prog_base, pp_byte_idx);
  assign pd_state     = pd;
  assign otp_state    = otp;

  a_r2_launch_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> $past(wel));
  a_r4_busy_blocks_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && cmd_valid) |=> !op_start);
  a_r5_hw_lock_blocks_wrsr: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && op_kind == K_WRSR) |-> $past(!(srp && !wp_n)));
  a_r8_sleep_silences: assert property (@(posedge clk) disable iff (!rst_n)
    (pd && cmd_valid && cmd_op != OPC_WAKE) |=> (!op_start && !rdsr_ack));
  a_r10_start_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> wip);
  a_r13_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !op_start);
endmodule

// File: tb/wp_cmd_gate_tb.sv
module wp_cmd_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TP = 20, TS = 40, TB32 = 60, TB64 = 80, TC = 100, TW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_op = 8'h00;
  logic [15:0] cmd_bits = 16'd0;
  logic [23:0] cmd_addr = 24'h0;
  logic [7:0]  cmd_data = 8'h00;
  logic        wp_n = 1'b1;
  logic [7:0]  pp_byte_idx = 8'h00;
  logic [7:0]  status_q;
  logic        op_start, rdsr_ack, wake_ack, pd_state, otp_state;
  logic [2:0]  op_kind;
  logic [23:0] op_addr, pp_byte_addr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wp_cmd_gate #(.BITS_W(16), .T_PROG(TP), .T_SECT(TS), .T_BLK32(TB32),
                .T_BLK64(TB64), .T_CHIP(TC), .T_WRSR(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bits(cmd_bits), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .wp_n(wp_n), .pp_byte_idx(pp_byte_idx), .status_q(status_q),
    .op_start(op_start), .op_kind(op_kind), .op_addr(op_addr),
    .pp_byte_addr(pp_byte_addr), .rdsr_ack(rdsr_ack), .wake_ack(wake_ack),
    .pd_state(pd_state), .otp_state(otp_state)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One command; returns at the falling edge after the accepting rising edge.
  task automatic send(input logic [7:0] op, input int bits,
                      input logic [23:0] addr, input logic [7:0] data);
    @(negedge clk);
    cmd_op = op; cmd_bits = 16'(bits); cmd_addr = addr; cmd_data = data;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      if (!status_q[0]) break;
      @(negedge clk);
    end
  endtask

  task automatic wrsr(input logic [7:0] v);
    send(8'h06, 8, 24'h0, 8'h00);
    send(8'h01, 16, 24'h0, v);
    wait_idle();
  endtask

  task automatic t_reset();
    chk("R11 reset status", 32'(status_q), 32'h00);
    chk("R13 reset op_start", 32'(op_start), 0);
  endtask

  task automatic t_latch();
    send(8'h06, 8, 24'h0, 8'h00);
    chk("R1 wren sets latch", 32'(status_q), 32'h02);
    send(8'h04, 8, 24'h0, 8'h00);
    chk("R1 wrdi clears latch", 32'(status_q), 32'h00);
    send(8'h02, 40, 24'h001000, 8'h00);
    chk("R2 program without latch refused", 32'(op_start), 0);
  endtask

  task automatic t_program_timing();
    send(8'h06, 8, 24'h0, 8'h00);
    send(8'h02, 41, 24'h0012F0, 8'h00);
    chk("R3 misaligned program refused", 32'(op_start), 0);
    chk("R3 latch kept after refusal", 32'(status_q), 32'h02);
    send(8'h02, 40, 24'h0012F0, 8'h00);
    chk("R13 program start", 32'(op_start), 1);
    chk("R13 program kind", 32'(op_kind), 0);
    chk("R13 program addr", 32'(op_addr), 32'h0012F0);
    chk("R10 busy with start", 32'(status_q[0]), 1);
    pp_byte_idx = 8'h20;
    #1;
    chk("R9 page wrap address", 32'(pp_byte_addr), 32'h001210);
    pp_byte_idx = 8'h05;
    #1;
    chk("R9 in-page address", 32'(pp_byte_addr), 32'h0012F5);
    repeat (TP - 1) @(negedge clk);
    chk("R10 busy at last cycle", 32'(status_q[0]), 1);
    @(negedge clk);
    chk("R10 busy cleared", 32'(status_q[0]), 0);
    chk("R1 latch cleared at completion", 32'(status_q[1]), 0);
  endtask

  task automatic t_busy_ignore();
    send(8'h06, 8, 24'h0, 8'h00);
    send(8'h20, 32, 24'h003000, 8'h00);
    chk("R13 sector kind", 32'(op_kind), 1);
    send(8'h06, 8, 24'h0, 8'h00);
    send(8'h05, 16, 24'h0, 8'h00);
    chk("R4 status read while busy", 32'(rdsr_ack), 1);
    send(8'hB9, 8, 24'h0, 8'h00);
    chk("R4 sleep ignored while busy", 32'(pd_state), 0);
    wait_idle();
    chk("R4 busy-time wren left no latch", 32'(status_q), 32'h00);
  endtask

  task automatic t_wrsr_len();
    send(8'h06, 8, 24'h0, 8'h00);
    send(8'h01, 20, 24'h0, 8'h10);
    chk("R3 status write 20 bits refused", 32'(op_start), 0);
    send(8'h01, 24, 24'h0, 8'h10);
    chk("R3 status write 24 bits accepted", 32'(op_start), 1);
    chk("R13 status write kind", 32'(op_kind), 5);
    wait_idle();
    chk("R11 status write loads BP2", 32'(status_q), 32'h10);
    send(8'h06, 8, 24'h0, 8'h00);
    send(8'h02, 40, 24'h00F000, 8'h00);
    chk("R6 BP2 alone protects nothing", 32'(op_start), 1);
    wait_idle();
  endtask

  task automatic t_protect();
    wrsr(8'h04);
    chk("R11 BP0 upper layout", 32'(status_q), 32'h04);
    send(8'h06, 8, 24'h0, 8'h00);
    send(8'h02, 40, 24'h009000, 8'h00);
    chk("R7 upper program refused", 32'(op_start), 0);
    send(8'h02, 40, 24'h001000, 8'h00);
    chk("R6 lower program allowed", 32'(op_start), 1);
    wait_idle();
    send(8'h06, 8, 24'h0, 8'h00);
    send(8'hC7, 8, 24'h0, 8'h00);
    chk("R7 chip erase refused", 32'(op_start), 0);
    send(8'hD8, 32, 24'h000000, 8'h00);
    chk("R7 64K erase refused", 32'(op_start), 0);
    send(8'h04, 8, 24'h0, 8'h00);
    wrsr(8'h24);
    chk("R11 TB layout", 32'(status_q), 32'h24);
    send(8'h06, 8, 24'h0, 8'h00);
    send(8'h20, 32, 24'h001000, 8'h00);
    chk("R6 TB=1 lower sector refused", 32'(op_start), 0);
    send(8'h20, 32, 24'h009000, 8'h00);
    chk("R6 TB=1 upper sector allowed", 32'(op_start), 1);
    wait_idle();
    wrsr(8'h08);
    send(8'h06, 8, 24'h0, 8'h00);
    send(8'h52, 32, 24'h000000, 8'h00);
    chk("R6 BP1 lower 32K refused", 32'(op_start), 0);
    send(8'h52, 32, 24'h008000, 8'h00);
    chk("R6 BP1 upper 32K refused", 32'(op_start), 0);
    send(8'h04, 8, 24'h0, 8'h00);
    wrsr(8'h00);
    send(8'h06, 8, 24'h0, 8'h00);
    send(8'h60, 8, 24'h0, 8'h00);
    chk("R13 chip erase kind", 32'(op_kind), 4);
    wait_idle();
  endtask

  task automatic t_hw_lock();
    wrsr(8'h80);
    chk("R11 SRP layout", 32'(status_q), 32'h80);
    wp_n = 1'b0;
    send(8'h06, 8, 24'h0, 8'h00);
    send(8'h01, 16, 24'h0, 8'h00);
    chk("R5 locked status write refused", 32'(op_start), 0);
    wp_n = 1'b1;
    send(8'h01, 16, 24'h0, 8'h00);
    chk("R5 unlocked status write accepted", 32'(op_start), 1);
    wait_idle();
    chk("R5 status cleared", 32'(status_q), 32'h00);
  endtask

  task automatic t_sleep();
    send(8'hB9, 8, 24'h0, 8'h00);
    chk("R8 enter power-down", 32'(pd_state), 1);
    send(8'h05, 16, 24'h0, 8'h00);
    chk("R8 status read ignored", 32'(rdsr_ack), 0);
    send(8'h06, 8, 24'h0, 8'h00);
    chk("R8 wren ignored", 32'(status_q), 32'h00);
    send(8'hAB, 32, 24'h0, 8'h00);
    chk("R8 release acknowledged", 32'(wake_ack), 1);
    chk("R8 power-down left", 32'(pd_state), 0);
    send(8'h05, 16, 24'h0, 8'h00);
    chk("R4 status read after wake", 32'(rdsr_ack), 1);
  endtask

  task automatic t_otp();
    send(8'h3A, 8, 24'h0, 8'h00);
    chk("R12 OTP entered", 32'(otp_state), 1);
    wrsr(8'h1C);
    chk("R12 OTP write sets only lock", 32'(status_q), 32'h80);
    send(8'h04, 8, 24'h0, 8'h00);
    chk("R12 OTP left", 32'(otp_state), 0);
    wrsr(8'h00);
    chk("R12 normal write after OTP", 32'(status_q), 32'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch();
    t_program_timing();
    t_busy_ignore();
    t_wrsr_len();
    t_protect();
    t_hw_lock();
    t_sleep();
    t_otp();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule